// File: doc/BRIEF.md
# Streaming 3x3 Neighbourhood Former

This block turns a raster stream of grayscale pixels from a square image of side `IMG_W` into a sliding 3x3 neighbourhood. It accepts one pixel per cycle in which `pixValid` is high. Two row stores, each `IMG_W` entries deep, keep the two rows that came before the current one. The current row is written into whichever store holds the older of those two rows. A one-bit phase chooses that store, and the phase flips after the last column of each row. A neighbourhood filter such as a median or rank stage sits downstream. It reads all nine pixels of the window together with a one-cycle valid pulse.

In each accepted cycle, both stores are read at the current column. The results form a three-pixel column together with the incoming pixel. The stores are ordered by phase so that the oldest row is always on top. That column shifts into a 3x3 register array. The window is marked valid only when its centre is an interior pixel. Frames follow one another with no gap, and the counters wrap at the last pixel of each frame.

Top module: `window3_gen`

## Requirements
- R1: A synchronous reset clears the column counter, the row counter and the phase. After reset, `winValid` is low. No window is flagged valid until two whole rows and three pixels of the third row have been accepted.
- R2: `winValid` is high for exactly the one cycle that follows acceptance of the pixel at row r and column c, where r >= 2 and c >= 2 (both counted from 0). At all other times it is low. Each row from 2 to IMG_W-1 therefore yields IMG_W-2 valid windows.
- R3: When `winValid` is high, window element (i, j) equals image pixel (r-2+i, c-2+j), where i is the window row (0 is the top) and j is the window column (0 is the left). The element sits at `winOut[(3*i+j)*PIX_W +: PIX_W]`.
- R4: A cycle in which `pixValid` is low changes nothing: `winOut` holds its value, `winValid` stays low, and the position in the image does not advance.
- R5: Even rows are written into store A and odd rows into store B. No cycle writes both stores. No cycle without an accepted pixel writes either store. The phase flips after column IMG_W-1 and returns to A at the start of every frame.
- R6: The read of a store happens before the write to it in the same cycle. The pixel from two rows back at the current column therefore reaches the top window row in the same cycle in which that store entry is overwritten.
- R7: After IMG_W*IMG_W accepted pixels, the next frame begins at row 0, column 0. No window in that frame contains a pixel of the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Accept `pixIn` in this cycle |
| pixIn | input | PIX_W | Incoming pixel, raster order |
| winValid | output | 1 | Window holds an interior neighbourhood (one-cycle pulse) |
| winOut | output | 9*PIX_W | Nine window pixels, element (i,j) at bits (3*i+j)*PIX_W |

## Verification
Two things coincide in this block. In every cycle of row 2 onward, a store entry is overwritten in the same cycle it is read for the top window row. At the last column of a row, the phase flips in the same cycle that the row's final valid window is formed. The bench streams frames whose pixel values are an arithmetic function of frame, row and column, with stall cycles inserted at varied columns. It checks every valid window element against that function, so a write-before-read order or an early or late phase flip shows up as a wrong top or middle row. The bench also counts valid pulses per row and checks the frame that follows, to catch leftovers of the previous frame.

// File: rtl/window3_pkg.sv
package window3_pkg;
  typedef struct packed {
    logic wrBufA;   // write incoming pixel into store A
    logic wrBufB;   // write incoming pixel into store B
    logic shiftEn;  // shift a new column into the window
    logic topSelB;  // store B holds the oldest row
  } win_strobe_t;
endpackage

// File: rtl/window3_linebuf.sv
module window3_linebuf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  // asynchronous read returns the old entry during a same-cycle write
  assign rdData = mem[addr];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end
endmodule

// File: rtl/window3_ctrl.sv
module window3_ctrl
  import window3_pkg::*;
#(
  parameter int IMG_W = 8,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pixValid,
  output win_strobe_t   strb,
  output logic [CW-1:0] colIdx,
  output logic          winValid
);
  logic [CW-1:0] colCnt, rowCnt;
  logic          phase;
  logic          validQ;
  logic          lastCol, lastRow, interior;

  assign lastCol  = (colCnt == CW'(IMG_W - 1));
  assign lastRow  = (rowCnt == CW'(IMG_W - 1));
  assign interior = (rowCnt >= CW'(2)) && (colCnt >= CW'(2));

  always_ff @(posedge clk) begin
    if (rst) begin
      colCnt <= '0;
      rowCnt <= '0;
      phase  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      validQ <= pixValid && interior;
      if (pixValid) begin
        if (lastCol) begin
          colCnt <= '0;
          if (lastRow) begin
            rowCnt <= '0;
            phase  <= 1'b0;
          end else begin
            rowCnt <= rowCnt + CW'(1);
            phase  <= ~phase;
          end
        end else begin
          colCnt <= colCnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    strb.wrBufA  = pixValid && !phase;
    strb.wrBufB  = pixValid && phase;
    strb.shiftEn = pixValid;
    strb.topSelB = phase;
  end

  assign colIdx   = colCnt;
  assign winValid = validQ;
endmodule

// File: rtl/window3_datapath.sv
module window3_datapath
  import window3_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int PIX_W = 8,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic             clk,
  input  win_strobe_t      strb,
  input  logic [CW-1:0]    colIdx,
  input  logic [PIX_W-1:0] pixIn,
  output logic [9*PIX_W-1:0] winOut
);
  logic [PIX_W-1:0] bufRd [2];
  logic [1:0]       bufWr;
  logic [PIX_W-1:0] colIn [3];
  logic [PIX_W-1:0] winReg [3][3];

  assign bufWr = {strb.wrBufB, strb.wrBufA};

  for (genvar b = 0; b < 2; b++) begin : g_store
    window3_linebuf #(.DEPTH(IMG_W), .DW(PIX_W)) u_store (
      .clk    (clk),
      .wrEn   (bufWr[b]),
      .addr   (colIdx),
      .wrData (pixIn),
      .rdData (bufRd[b])
    );
  end

  // oldest row on top, newer stored row in the middle, live pixel at bottom
  assign colIn[0] = strb.topSelB ? bufRd[1] : bufRd[0];
  assign colIn[1] = strb.topSelB ? bufRd[0] : bufRd[1];
  assign colIn[2] = pixIn;

  for (genvar i = 0; i < 3; i++) begin : g_row
    always_ff @(posedge clk) begin
      if (strb.shiftEn) begin
        winReg[i][0] <= winReg[i][1];
        winReg[i][1] <= winReg[i][2];
        winReg[i][2] <= colIn[i];
      end
    end
    for (genvar j = 0; j < 3; j++) begin : g_col
      assign winOut[(3*i+j)*PIX_W +: PIX_W] = winReg[i][j];
    end
  end
endmodule

// File: rtl/window3_gen.sv
module window3_gen
  import window3_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int PIX_W = 8,
  localparam int CW   = (IMG_W > 1) ? $clog2(IMG_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pixValid,
  input  logic [PIX_W-1:0]   pixIn,
  output logic               winValid,
  output logic [9*PIX_W-1:0] winOut
);
  win_strobe_t   ctrlStrb;
  logic [CW-1:0] colIdx;

  window3_ctrl #(.IMG_W(IMG_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pixValid (pixValid),
    .strb     (ctrlStrb),
    .colIdx   (colIdx),
    .winValid (winValid)
  );

  window3_datapath #(.IMG_W(IMG_W), .PIX_W(PIX_W)) u_dp (
    .clk    (clk),
    .strb   (ctrlStrb),
    .colIdx (colIdx),
    .pixIn  (pixIn),
    .winOut (winOut)
  );
endmodule

// File: rtl/window3_gen_chk.sv
module window3_gen_chk #(
  parameter int PIX_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pixValid,
  input logic               winValid,
  input logic [9*PIX_W-1:0] winOut,
  input logic               wrBufA,
  input logic               wrBufB
);
  assert_one_store_R5: assert property (@(posedge clk) disable iff (rst)
    !(wrBufA && wrBufB));

  assert_write_needs_pixel_R5: assert property (@(posedge clk) disable iff (rst)
    (wrBufA || wrBufB) |-> pixValid);

  assert_valid_follows_accept_R2: assert property (@(posedge clk) disable iff (rst)
    winValid |-> $past(pixValid));

  assert_stall_holds_window_R4: assert property (@(posedge clk) disable iff (rst)
    !pixValid |=> ($stable(winOut) && !winValid));

  assert_reset_clears_valid_R1: assert property (@(posedge clk)
    rst |=> !winValid);
endmodule

bind window3_gen window3_gen_chk #(.PIX_W(PIX_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .pixValid (pixValid),
  .winValid (winValid),
  .winOut   (winOut),
  .wrBufA   (ctrlStrb.wrBufA),
  .wrBufB   (ctrlStrb.wrBufB)
);

// File: tb/test_window3_gen.sv
`timescale 1ns/100ps
module test_window3_gen;
  localparam int IMG_W = 6;
  localparam int PIX_W = 8;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               pixValid = 1'b0;
  logic [PIX_W-1:0]   pixIn = '0;
  logic               winValid;
  logic [9*PIX_W-1:0] winOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  window3_gen #(.IMG_W(IMG_W), .PIX_W(PIX_W)) i_window3_gen (
    .clk, .rst, .pixValid, .pixIn, .winValid, .winOut
  );

  function automatic logic [PIX_W-1:0] pv(input int fr, input int r, input int c);
    return PIX_W'((fr*97 + r*31 + c*7 + r*c*3 + 5) & 255);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic sendPix(input int fr, input int r, input int c, inout int rowValids);
    bit expV;
    pixValid = 1'b1;
    pixIn    = pv(fr, r, c);
    @(negedge clk);
    pixValid = 1'b0;
    expV = (r >= 2) && (c >= 2);
    chk("R2", "winValid", int'(winValid), int'(expV));
    if (winValid) rowValids++;
    if (expV) begin
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          chk((i == 0) ? "R6" : ((fr > 0) ? "R7" : "R3"), "window element",
              int'(winOut[(3*i+j)*PIX_W +: PIX_W]), int'(pv(fr, r-2+i, c-2+j)));
    end
  endtask

  task automatic stall(input int n);
    logic [9*PIX_W-1:0] prev;
    prev = winOut;
    pixValid = 1'b0;
    repeat (n) begin
      @(negedge clk);
      chk("R4", "winValid during stall", int'(winValid), 0);
      checks++;
      if (winOut !== prev) begin
        failures++;
        $display("FAIL R4 window moved during stall actual=%h expected=%h", winOut, prev);
      end
    end
  endtask

  task automatic sendFrame(input int fr, input int rows, input bit withStalls);
    for (int r = 0; r < rows; r++) begin
      int rowValids = 0;
      for (int c = 0; c < IMG_W; c++) begin
        sendPix(fr, r, c, rowValids);
        if (withStalls && ((r + c) % 4 == 1)) stall(1 + (c % 2));
      end
      chk("R2", "valid windows in row", rowValids, (r >= 2) ? IMG_W - 2 : 0);
    end
  endtask

  task automatic doReset;
    rst = 1'b1;
    pixValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "winValid after reset", int'(winValid), 0);
  endtask

  initial begin
    @(negedge clk);
    doReset();
    sendFrame(0, IMG_W, 1'b1);   // R3, R4, R5, R6 with stalls
    sendFrame(1, IMG_W, 1'b0);   // R7 back-to-back frame
    sendFrame(2, 3, 1'b1);       // partial frame, then reset mid-row
    begin
      int dummy = 0;
      sendPix(3, 3, 0, dummy);   // row 3 expects no valid at column 0
    end
    doReset();
    sendFrame(4, IMG_W, 1'b1);   // R1: fresh start after mid-frame reset
    stall(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule